// File: doc/BRIEF.md
# 64-bit Bit-Manipulation Execution Unit

This block is a single-stage execution unit for a group of basic bit-manipulation operations on 64-bit integers. Each cycle it can accept one operation: a 5-bit operation code, two 64-bit source operands and a 6-bit immediate, qualified by a valid strobe. One clock later it presents the 64-bit result with its own valid strobe.

The unit supports:
- leading-zero, trailing-zero and set-bit counts;
- reversal of the byte order of the whole register;
- and, or and exclusive-or with the second operand inverted;
- sign and zero extension of narrow fields;
- signed and unsigned minimum and maximum;
- left and right rotation;
- a per-byte or-reduction that exposes zero bytes, as used in string scanning.

Counts and rotations also come in word forms. A word form works on the low 32 bits of its inputs and sign-extends its 32-bit result to 64 bits. Instruction decode and the register file sit outside this block.

Top module: `bitmanip_unit`

## Requirements
- R1: `out_valid` equals the value `in_valid` had one clock earlier, and `result` is loaded only in cycles with `in_valid` high. With `in_valid` low, `result` keeps its previous value and `op`, `src_a`, `src_b` and `imm` have no effect.
- R2: While `rst_n` is low, `out_valid` is 0 and `result` is 0.
- R3: Op 0 returns the count of leading zeros of `src_a`, and op 2 returns the count of trailing zeros. Ops 1 and 3 do the same over `src_a[31:0]`. An all-zero input returns 64 for ops 0 and 2 and 32 for ops 1 and 3.
- R4: Op 4 returns the number of set bits in `src_a`, and op 5 returns the number of set bits in `src_a[31:0]`.
- R5: The result of every word form (ops 1, 3, 5, 18, 20 and 22) depends only on bits 31:0 of its inputs, and its bits 63:32 repeat bit 31.
- R6: Op 6 returns `src_a` with its eight bytes in reverse order.
- R7: Op 7 returns `src_a & ~src_b`, op 8 returns `src_a | ~src_b`, and op 9 returns `~(src_a ^ src_b)`.
- R8: Op 10 sign-extends `src_a[7:0]`, op 11 sign-extends `src_a[15:0]`, and op 12 zero-extends `src_a[15:0]`, each to 64 bits.
- R9: Op 13 returns the signed minimum of `src_a` and `src_b`, op 14 the unsigned minimum, op 15 the signed maximum and op 16 the unsigned maximum.
- R10: Op 17 rotates `src_a` left and op 19 rotates it right, by `src_b[5:0]`. Op 18 rotates `src_a[31:0]` left and op 20 rotates it right, by `src_b[4:0]`. All other bits of `src_b` are ignored.
- R11: Op 21 rotates `src_a` right by `imm[5:0]`, and op 22 rotates `src_a[31:0]` right by `imm[4:0]`. Both ignore `src_b`.
- R12: For op 23, each result byte is 8'hFF if the matching byte of `src_a` has any bit set, and 8'h00 otherwise.
- R13: Op codes 24 to 31 return a result of 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operation request strobe |
| op | input | 5 | Operation code |
| src_a | input | 64 | First operand |
| src_b | input | 64 | Second operand, or rotation amount |
| imm | input | 6 | Immediate rotation amount |
| out_valid | output | 1 | Result valid, one cycle after `in_valid` |
| result | output | 64 | Registered result |

## Verification
The bench targets all-zero and all-ones operands for the counts. A counter without a zero-input case would return 63 or 31 rather than the full width, and a word count that leaked upper bits would exceed 32. Signed boundary values are paired against small ones, so a signed min/max that compared unsigned would pick the wrong operand. Rotation amounts of 0, 31, 32 and 63 are used with junk in the unused amount bits and in `src_b` for the immediate forms, which exposes amounts taken too wide and word results that are not sign-extended. Random values with scattered zero bytes catch an or-combine that sets the wrong lanes, and idle cycles with changing inputs catch a result register that loads without `in_valid`.

// File: rtl/bmu_pkg.sv
package bmu_pkg;

  typedef enum logic [4:0] {
    OP_CLZ   = 5'd0,
    OP_CLZW  = 5'd1,
    OP_CTZ   = 5'd2,
    OP_CTZW  = 5'd3,
    OP_CPOP  = 5'd4,
    OP_CPOPW = 5'd5,
    OP_REV8  = 5'd6,
    OP_ANDN  = 5'd7,
    OP_ORN   = 5'd8,
    OP_XNOR  = 5'd9,
    OP_SEXTB = 5'd10,
    OP_SEXTH = 5'd11,
    OP_ZEXTH = 5'd12,
    OP_MIN   = 5'd13,
    OP_MINU  = 5'd14,
    OP_MAX   = 5'd15,
    OP_MAXU  = 5'd16,
    OP_ROL   = 5'd17,
    OP_ROLW  = 5'd18,
    OP_ROR   = 5'd19,
    OP_RORW  = 5'd20,
    OP_RORI  = 5'd21,
    OP_RORIW = 5'd22,
    OP_ORCB  = 5'd23
  } bmu_op_e;

  localparam int unsigned OP_LAST = 23;

endpackage

// File: rtl/bmu_counter.sv
module bmu_counter #(
  parameter int W  = 64,
  localparam int CW = $clog2(W) + 1
) (
  input  logic [W-1:0]  data,
  output logic [CW-1:0] lead,
  output logic [CW-1:0] trail,
  output logic [CW-1:0] ones
);

  // Leading zeros: first set bit scanning down from the MSB.
  always_comb begin
    logic hit;
    hit  = 1'b0;
    lead = CW'(W);
    for (int i = W - 1; i >= 0; i--) begin
      if (!hit && data[i]) begin
        lead = CW'(W - 1 - i);
        hit  = 1'b1;
      end
    end
  end

  // Trailing zeros: first set bit scanning up from the LSB.
  always_comb begin
    logic hit;
    hit   = 1'b0;
    trail = CW'(W);
    for (int i = 0; i < W; i++) begin
      if (!hit && data[i]) begin
        trail = CW'(i);
        hit   = 1'b1;
      end
    end
  end

  always_comb begin
    ones = '0;
    for (int i = 0; i < W; i++) begin
      ones = ones + CW'(data[i]);
    end
  end

endmodule

// File: rtl/bmu_rotator.sv
module bmu_rotator #(
  parameter int W  = 64,
  localparam int SW = $clog2(W)
) (
  input  logic [W-1:0]  data,
  input  logic [SW-1:0] amount,
  input  logic          to_left,
  output logic [W-1:0]  rotated
);

  logic [2*W-1:0] doubled;
  logic [2*W-1:0] shifted;
  logic [SW-1:0]  right_amt;

  // A left rotate by s equals a right rotate by (W - s) mod W.
  assign right_amt = to_left ? (SW'(0) - amount) : amount;
  assign doubled   = {data, data};
  assign shifted   = doubled >> right_amt;
  assign rotated   = shifted[W-1:0];

endmodule

// File: rtl/bmu_bytewise.sv
module bmu_bytewise #(
  parameter int W  = 64,
  localparam int NB = W / 8
) (
  input  logic [W-1:0] data,
  output logic [W-1:0] swapped,
  output logic [W-1:0] or_comb
);

  for (genvar g = 0; g < NB; g++) begin : g_lane
    assign swapped[8*g +: 8] = data[8*(NB-1-g) +: 8];
    assign or_comb[8*g +: 8] = {8{|data[8*g +: 8]}};
  end

endmodule

// File: rtl/bitmanip_unit.sv
module bitmanip_unit
  import bmu_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      in_valid,
  input  logic [4:0]                op,
  input  logic [XLEN-1:0]           src_a,
  input  logic [XLEN-1:0]           src_b,
  input  logic [$clog2(XLEN)-1:0]   imm,
  output logic                      out_valid,
  output logic [XLEN-1:0]           result
);

  localparam int WLEN = XLEN / 2;
  localparam int SHF  = $clog2(XLEN);
  localparam int SHW  = $clog2(WLEN);
  localparam int CF   = SHF + 1;
  localparam int CW   = SHW + 1;

  function automatic logic [XLEN-1:0] word_ext(input logic [WLEN-1:0] v);
    return {{(XLEN-WLEN){v[WLEN-1]}}, v};
  endfunction

  bmu_op_e         op_e;
  logic [CF-1:0]   lz_f, tz_f, pc_f;
  logic [CW-1:0]   lz_w, tz_w, pc_w;
  logic [XLEN-1:0] rot_f;
  logic [WLEN-1:0] rot_w;
  logic [SHF-1:0]  amt_f;
  logic [SHW-1:0]  amt_w;
  logic [XLEN-1:0] rev_bytes, orc_bytes;
  logic            a_lt_s, a_lt_u;
  logic [XLEN-1:0] res_d;

  assign op_e = bmu_op_e'(op);

  bmu_counter #(.W(XLEN)) u_cnt_full (
    .data (src_a),
    .lead (lz_f),
    .trail(tz_f),
    .ones (pc_f)
  );

  bmu_counter #(.W(WLEN)) u_cnt_word (
    .data (src_a[WLEN-1:0]),
    .lead (lz_w),
    .trail(tz_w),
    .ones (pc_w)
  );

  assign amt_f = (op_e == OP_RORI)  ? imm            : src_b[SHF-1:0];
  assign amt_w = (op_e == OP_RORIW) ? imm[SHW-1:0]   : src_b[SHW-1:0];

  bmu_rotator #(.W(XLEN)) u_rot_full (
    .data   (src_a),
    .amount (amt_f),
    .to_left(op_e == OP_ROL),
    .rotated(rot_f)
  );

  bmu_rotator #(.W(WLEN)) u_rot_word (
    .data   (src_a[WLEN-1:0]),
    .amount (amt_w),
    .to_left(op_e == OP_ROLW),
    .rotated(rot_w)
  );

  bmu_bytewise #(.W(XLEN)) u_bytes (
    .data   (src_a),
    .swapped(rev_bytes),
    .or_comb(orc_bytes)
  );

  assign a_lt_s = $signed(src_a) < $signed(src_b);
  assign a_lt_u = src_a < src_b;

  // Next-state: operation select
  always_comb begin
    res_d = '0;
    unique case (op_e)
      OP_CLZ:   res_d = XLEN'(lz_f);
      OP_CLZW:  res_d = XLEN'(lz_w);
      OP_CTZ:   res_d = XLEN'(tz_f);
      OP_CTZW:  res_d = XLEN'(tz_w);
      OP_CPOP:  res_d = XLEN'(pc_f);
      OP_CPOPW: res_d = XLEN'(pc_w);
      OP_REV8:  res_d = rev_bytes;
      OP_ANDN:  res_d = src_a & ~src_b;
      OP_ORN:   res_d = src_a | ~src_b;
      OP_XNOR:  res_d = ~(src_a ^ src_b);
      OP_SEXTB: res_d = {{(XLEN-8){src_a[7]}}, src_a[7:0]};
      OP_SEXTH: res_d = {{(XLEN-16){src_a[15]}}, src_a[15:0]};
      OP_ZEXTH: res_d = {{(XLEN-16){1'b0}}, src_a[15:0]};
      OP_MIN:   res_d = a_lt_s ? src_a : src_b;
      OP_MINU:  res_d = a_lt_u ? src_a : src_b;
      OP_MAX:   res_d = a_lt_s ? src_b : src_a;
      OP_MAXU:  res_d = a_lt_u ? src_b : src_a;
      OP_ROL, OP_ROR, OP_RORI:     res_d = rot_f;
      OP_ROLW, OP_RORW, OP_RORIW:  res_d = word_ext(rot_w);
      OP_ORCB:  res_d = orc_bytes;
      default:  res_d = '0;
    endcase
  end

  // Result register with explicit load enable
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      result    <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        result <= res_d;
      end
    end
  end

endmodule

// File: rtl/bmu_checker.sv
module bmu_checker
  import bmu_pkg::*;
#(
  parameter int XLEN = 64
) (
  input logic            clk,
  input logic            rst_n,
  input logic            in_valid,
  input logic [4:0]      op,
  input logic            out_valid,
  input logic [XLEN-1:0] result
);

  localparam int NB = XLEN / 8;

  logic [NB-1:0] lane_ok;
  for (genvar g = 0; g < NB; g++) begin : g_lane
    assign lane_ok[g] = (result[8*g +: 8] == 8'h00) || (result[8*g +: 8] == 8'hFF);
  end

  // R1
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  // R1
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && $stable(result)));

  // R3
  count_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && ($past(op) == OP_CLZ || $past(op) == OP_CTZ)) |-> (result <= XLEN));

  // R4
  pop_word_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(op) == OP_CPOPW) |-> (result <= XLEN/2));

  // R5
  word_sext_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && ($past(op) == OP_ROLW || $past(op) == OP_RORW || $past(op) == OP_RORIW))
      |-> (result[XLEN-1:XLEN/2] == {(XLEN/2){result[XLEN/2-1]}}));

  // R12
  orcb_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(op) == OP_ORCB) |-> (&lane_ok));

  // R13
  unused_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(op) > 5'(OP_LAST)) |-> (result == '0));

endmodule

bind bitmanip_unit bmu_checker #(.XLEN(XLEN)) u_bmu_checker (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_valid (in_valid),
  .op       (op),
  .out_valid(out_valid),
  .result   (result)
);

// File: tb/test_bitmanip_unit.sv
module test_bitmanip_unit;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [4:0]  op;
  logic [63:0] src_a, src_b;
  logic [5:0]  imm;
  logic        out_valid;
  logic [63:0] result;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bitmanip_unit #(.XLEN(64)) i_bitmanip_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op),
    .src_a(src_a), .src_b(src_b), .imm(imm),
    .out_valid(out_valid), .result(result)
  );

  function automatic logic [63:0] sx32(input logic [31:0] v);
    return {{32{v[31]}}, v};
  endfunction

  function automatic string tag_of(input int c);
    case (c)
      0, 2:        return "R3";
      1, 3:        return "R3/R5";
      4:           return "R4";
      5:           return "R4/R5";
      6:           return "R6";
      7, 8, 9:     return "R7";
      10, 11, 12:  return "R8";
      13, 14, 15, 16: return "R9";
      17, 19:      return "R10";
      18, 20:      return "R10/R5";
      21:          return "R11";
      22:          return "R11/R5";
      23:          return "R12";
      default:     return "R13";
    endcase
  endfunction

  function automatic logic [63:0] model(input int c, input logic [63:0] a,
                                        input logic [63:0] b, input logic [5:0] im);
    logic [63:0] r;
    logic [31:0] w;
    int n, s;
    r = '0;
    w = a[31:0];
    case (c)
      0: begin n = 0; while (n < 64 && !a[63-n]) n++; r = 64'(n); end
      1: begin n = 0; while (n < 32 && !w[31-n]) n++; r = 64'(n); end
      2: begin n = 0; while (n < 64 && !a[n]) n++; r = 64'(n); end
      3: begin n = 0; while (n < 32 && !w[n]) n++; r = 64'(n); end
      4: r = 64'($countones(a));
      5: r = 64'($countones(w));
      6: for (int k = 0; k < 8; k++) r[8*k +: 8] = a[8*(7-k) +: 8];
      7: r = a & ~b;
      8: r = a | ~b;
      9: r = ~(a ^ b);
      10: r = {{56{a[7]}}, a[7:0]};
      11: r = {{48{a[15]}}, a[15:0]};
      12: r = {48'h0, a[15:0]};
      13: r = ($signed(a) < $signed(b)) ? a : b;
      14: r = (a < b) ? a : b;
      15: r = ($signed(a) > $signed(b)) ? a : b;
      16: r = (a > b) ? a : b;
      17: begin s = int'(b[5:0]); r = (a << s) | (a >> (64 - s)); end
      18: begin s = int'(b[4:0]); r = sx32((w << s) | (w >> (32 - s))); end
      19: begin s = int'(b[5:0]); r = (a >> s) | (a << (64 - s)); end
      20: begin s = int'(b[4:0]); r = sx32((w >> s) | (w << (32 - s))); end
      21: begin s = int'(im); r = (a >> s) | (a << (64 - s)); end
      22: begin s = int'(im[4:0]); r = sx32((w >> s) | (w << (32 - s))); end
      23: for (int k = 0; k < 8; k++) r[8*k +: 8] = (a[8*k +: 8] != 8'h00) ? 8'hFF : 8'h00;
      default: r = '0;
    endcase
    return r;
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Called at a negedge; drives one op and checks it at the next negedge.
  task automatic do_op(input int c, input logic [63:0] a, input logic [63:0] b,
                       input logic [5:0] im);
    logic [63:0] exp;
    exp      = model(c, a, b, im);
    in_valid = 1'b1;
    op       = 5'(c);
    src_a    = a;
    src_b    = b;
    imm      = im;
    @(negedge clk);
    check({"R1 valid, op ", tag_of(c)}, {63'h0, out_valid}, 64'h1);
    check(tag_of(c), result, exp);
  endtask

  initial begin
    logic [63:0] held, a, b;
    int c;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; in_valid = 1'b0; op = '0; src_a = '0; src_b = '0; imm = '0;
    repeat (3) @(negedge clk);
    check("R2 reset out_valid", {63'h0, out_valid}, 64'h0);
    check("R2 reset result", result, 64'h0);
    rst_n = 1'b1;
    @(negedge clk);

    // Directed corner cases
    do_op(0, 64'h0, 64'h0, 6'h0);
    do_op(1, 64'hFFFF_FFFF_0000_0000, 64'h0, 6'h0);
    do_op(2, 64'h0, 64'h0, 6'h0);
    do_op(3, 64'h1234_5678_0000_0000, 64'h0, 6'h0);
    do_op(0, 64'h8000_0000_0000_0000, 64'h0, 6'h0);
    do_op(2, 64'h8000_0000_0000_0000, 64'h0, 6'h0);
    do_op(4, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 6'h0);
    do_op(5, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 6'h0);
    do_op(6, 64'h0011_2233_4455_6677, 64'h0, 6'h0);
    do_op(7, 64'hF0F0_F0F0_F0F0_F0F0, 64'hFF00_FF00_FF00_FF00, 6'h0);
    do_op(8, 64'h0, 64'hFF00_FF00_FF00_FF00, 6'h0);
    do_op(9, 64'hAAAA_5555_AAAA_5555, 64'hAAAA_AAAA_5555_5555, 6'h0);
    do_op(10, 64'h0000_0000_0000_0080, 64'h0, 6'h0);
    do_op(11, 64'hFFFF_FFFF_FFFF_7FFF, 64'h0, 6'h0);
    do_op(12, 64'hFFFF_FFFF_FFFF_8001, 64'h0, 6'h0);
    do_op(13, 64'h8000_0000_0000_0000, 64'h1, 6'h0);
    do_op(14, 64'h8000_0000_0000_0000, 64'h1, 6'h0);
    do_op(15, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1, 6'h0);
    do_op(16, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1, 6'h0);
    do_op(17, 64'h8000_0000_0000_0001, 64'hFFFF_FFFF_FFFF_FFC0, 6'h0);
    do_op(17, 64'h8000_0000_0000_0001, 64'h0000_0000_0000_00C1, 6'h0);
    do_op(19, 64'h0123_4567_89AB_CDEF, 64'h0000_0000_0000_007F, 6'h0);
    do_op(18, 64'hDEAD_BEEF_0000_0001, 64'hFFFF_FFFF_FFFF_FFFF, 6'h0);
    do_op(20, 64'h0000_0000_0000_0001, 64'h0000_0000_0000_0020, 6'h0);
    do_op(21, 64'h0123_4567_89AB_CDEF, 64'hFFFF_FFFF_FFFF_FFFF, 6'd32);
    do_op(22, 64'h0000_0000_8000_0000, 64'h0000_0000_0000_0005, 6'd32);
    do_op(22, 64'h0000_0000_0000_0001, 64'h0, 6'd1);
    do_op(23, 64'h0100_0000_8000_00F0, 64'h0, 6'h0);
    do_op(24, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 6'h3F);
    do_op(31, 64'h1234_5678_9ABC_DEF0, 64'h1, 6'h1);

    // Random mix
    for (int i = 0; i < 3000; i++) begin
      c = int'($urandom_range(0, 31));
      a = {$urandom, $urandom};
      b = {$urandom, $urandom};
      case ($urandom_range(0, 3))
        0: a = a >> $urandom_range(0, 63);
        1: a = a & {8{($urandom_range(0, 1) != 0) ? 8'hFF : 8'h00}} &
               {$urandom, $urandom};
        2: b = {1'b1, b[62:0]};
        default: ;
      endcase
      do_op(c, a, b, 6'($urandom));
    end

    // R1: idle cycles must leave the result untouched
    held     = result;
    in_valid = 1'b0;
    for (int i = 0; i < 4; i++) begin
      op    = 5'($urandom_range(0, 23));
      src_a = {$urandom, $urandom};
      src_b = {$urandom, $urandom};
      imm   = 6'($urandom);
      @(negedge clk);
      check("R1 idle out_valid", {63'h0, out_valid}, 64'h0);
      check("R1 idle result hold", result, held);
    end

    // R2: asynchronous reset mid-stream
    do_op(6, 64'h1122_3344_5566_7788, 64'h0, 6'h0);
    #(CLK_PERIOD/4) rst_n = 1'b0;
    #1;
    check("R2 async out_valid", {63'h0, out_valid}, 64'h0);
    check("R2 async result", result, 64'h0);
    done = 1'b1;
  end

  initial begin
    fork
      begin
        wait (done);
      end
      begin
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule